// File: doc/BRIEF.md
# Single-Port RAM with Selectable Read-During-Write Behaviour

This block is a word-addressed RAM with one address bus that serves both the read side and the write side. A write is split into byte-like lanes, and each lane has its own enable bit. Reads are either registered, with one clock of latency, or combinational. For a registered read, an elaboration parameter sets what a read returns when it hits the word being written in the same cycle. In old-data mode it returns the stored word from before the write. In new-data mode it returns the merged result of the write.

An optional read enable controls when the read side samples. The two registered modes treat it differently. In old-data mode the read data register is frozen while the enable is low. In new-data mode only the captured address is frozen, so the output keeps following that stored word, including later writes to it. Parameters can also remove the write path or the read enable. When they are removed, the matching inputs have no effect.

The memory depth need not be a power of two. Any address at or beyond the depth is inert: it writes nothing and reads as zero. A hold-output mode, in which the output keeps its value during writes, is rejected at elaboration, as is a lane width that does not divide the word.

Top module: `spram_rdw`

## Requirements
- R1: With registered read in old-data mode (RDW=0), a read of the address written in the same cycle returns, one clock later, the word as it was before that write.
- R2: With registered read in new-data mode (RDW=1), a read of the address written in the same cycle returns, one clock later, the word with that write applied.
- R3: Enable bit i of `wr_en` writes only data bits [i*G +: G], where G is LANE_W. All other bits of the addressed word keep their values.
- R4: When LANE_W is 0, or is at least DATA_W, `wr_en` is one bit wide and that bit writes the whole word.
- R5: With combinational read (SYNC_RD=0), `rd_data` shows the word at the current `addr` in the same cycle, including a write taken at the last clock edge, whatever the value of RDW.
- R6: In old-data mode with the read enable present, a cycle with `rd_en` low leaves `rd_data` unchanged at the next edge.
- R7: In new-data mode with the read enable present, a cycle with `rd_en` low keeps the captured address, and `rd_data` reflects any later write to that address.
- R8: When the read enable is absent (HAS_RE=0), `rd_en` is ignored and a registered read samples on every clock.
- R9: When the write path is absent (HAS_WR=0), `wr_en` and `wr_data` have no effect on the stored contents.
- R10: An address at or beyond DEPTH writes nothing and reads as zero.
- R11: While `rst_n` is low, the read-data register (old-data mode) is cleared to zero and the captured read address (new-data mode) is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for writes and registered reads |
| rst_n | input | 1 | Asynchronous active-low reset of the read-side registers |
| addr | input | AW = clog2(DEPTH) | Shared read/write word address |
| rd_en | input | 1 | Read enable, used only when HAS_RE=1 |
| rd_data | output | DATA_W | Read data |
| wr_data | input | DATA_W | Write data |
| wr_en | input | LANES | Per-lane write enables (1 bit when lanes fall back to the whole word) |

## Verification
The risky case is a write and a read of the same word in the same cycle, often with the read enable low or with only some lanes enabled. The bench makes this happen both on purpose and by drawing random addresses from a small range that includes addresses past the depth. It drives one stimulus stream into five instances at once: old-data, new-data, combinational, whole-word-fallback with no read enable, and read-only. Each output is compared with shadow arrays that apply the same lane masks. The old-data and new-data expectations are computed separately, so a read and write colliding on one address must give different, predicted values on the two registered instances.

// File: rtl/spram_pkg.sv
package spram_pkg;

  // Read-during-write selections
  localparam int RDW_OLD  = 0;
  localparam int RDW_NEW  = 1;
  localparam int RDW_HOLD = 2;

  // Number of write lanes; degenerate granularity collapses to one lane
  function automatic int lane_count(input int width, input int gran);
    if (gran <= 0 || gran >= width) return 1;
    return width / gran;
  endfunction

  // Bits covered by one lane
  function automatic int lane_bits(input int width, input int gran);
    return width / lane_count(width, gran);
  endfunction

  // Address width for a given depth
  function automatic int addr_bits(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction

  // True when the granularity does not tile the word
  function automatic bit gran_bad(input int width, input int gran);
    return (gran > 0) && (gran < width) && ((width % gran) != 0);
  endfunction

endpackage

// File: rtl/spram_lane_ctl.sv
module spram_lane_ctl
  import spram_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int AW     = 6,
  parameter int DEPTH  = 48,
  parameter int HAS_WR = 1
) (
  input  logic [AW-1:0]     addr,
  input  logic [LANES-1:0]  wr_en,
  output logic              addr_ok,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_bits
);

  localparam int LW = DATA_W / LANES;

  // Depth need not be a power of two
  assign addr_ok = (int'(addr) < DEPTH);

  // Expand each lane enable across its bits
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_bits[i*LW +: LW] = {LW{wr_en[i]}};
  end

  if (HAS_WR != 0) begin : g_wr
    assign wr_req = |wr_en;
  end else begin : g_nowr
    assign wr_req = 1'b0;
  end

endmodule

// File: rtl/spram_array.sv
module spram_array #(
  parameter int DATA_W = 16,
  parameter int AW     = 6,
  parameter int DEPTH  = 48
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_bits,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     tap_addr,
  output logic [DATA_W-1:0] tap_word
);

  logic [DATA_W-1:0] store [DEPTH];

  // Masked write; caller guarantees wr_addr is in range when wr_fire
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      store[wr_addr] <= (store[wr_addr] & ~wr_bits) | (wr_data & wr_bits);
    end
  end

  // Combinational tap; out-of-range reads return zero
  assign tap_word = (int'(tap_addr) < DEPTH) ? store[tap_addr] : '0;

endmodule

// File: rtl/spram_rd_path.sv
module spram_rd_path
  import spram_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int AW      = 6,
  parameter int RDW     = RDW_OLD,
  parameter int SYNC_RD = 1,
  parameter int HAS_RE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] tap_word,
  output logic [AW-1:0]     tap_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_capture
);

  if (HAS_RE != 0) begin : g_re
    assign rd_capture = rd_en;
  end else begin : g_nore
    assign rd_capture = 1'b1;
  end

  if (SYNC_RD == 0) begin : g_comb
    // No latency; mode does not matter
    assign tap_addr = addr;
    assign rd_data  = tap_word;
  end else if (RDW == RDW_OLD) begin : g_old
    // Data register samples the pre-write word
    logic [DATA_W-1:0] data_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          data_q <= '0;
      else if (rd_capture) data_q <= tap_word;
    end
    assign tap_addr = addr;
    assign rd_data  = data_q;
  end else begin : g_new
    // Address register; output tracks the word at the held address
    logic [AW-1:0] addr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr_q <= '0;
      else if (rd_capture) addr_q <= addr;
    end
    assign tap_addr = addr_q;
    assign rd_data  = tap_word;
  end

endmodule

// File: rtl/spram_rdw.sv
module spram_rdw
  import spram_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 48,
  parameter int LANE_W  = 8,
  parameter int RDW     = RDW_OLD,
  parameter int SYNC_RD = 1,
  parameter int HAS_WR  = 1,
  parameter int HAS_RE  = 1,
  localparam int AW     = addr_bits(DEPTH),
  localparam int LANES  = lane_count(DATA_W, LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_en
);

  // Elaboration checks
  if (RDW == RDW_HOLD) begin : g_err_hold
    $error("spram_rdw: hold-output read-during-write mode is not supported");
  end
  if (RDW != RDW_OLD && RDW != RDW_NEW && RDW != RDW_HOLD) begin : g_err_mode
    $error("spram_rdw: unknown read-during-write selection");
  end
  if (gran_bad(DATA_W, LANE_W)) begin : g_err_gran
    $error("spram_rdw: DATA_W must be a multiple of LANE_W");
  end
  if (DEPTH < 2) begin : g_err_depth
    $error("spram_rdw: DEPTH must be at least 2");
  end

  // Named internal events for the checker
  logic              addr_ok;
  logic              wr_req;
  logic              wr_fire;
  logic [DATA_W-1:0] wr_bits;
  logic [AW-1:0]     tap_addr;
  logic [DATA_W-1:0] tap_word;
  logic              rd_capture;

  spram_lane_ctl #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .AW     (AW),
    .DEPTH  (DEPTH),
    .HAS_WR (HAS_WR)
  ) u_lane (
    .addr    (addr),
    .wr_en   (wr_en),
    .addr_ok (addr_ok),
    .wr_req  (wr_req),
    .wr_bits (wr_bits)
  );

  assign wr_fire = wr_req & addr_ok;

  spram_array #(
    .DATA_W (DATA_W),
    .AW     (AW),
    .DEPTH  (DEPTH)
  ) u_array (
    .clk      (clk),
    .wr_fire  (wr_fire),
    .wr_addr  (addr),
    .wr_bits  (wr_bits),
    .wr_data  (wr_data),
    .tap_addr (tap_addr),
    .tap_word (tap_word)
  );

  spram_rd_path #(
    .DATA_W  (DATA_W),
    .AW      (AW),
    .RDW     (RDW),
    .SYNC_RD (SYNC_RD),
    .HAS_RE  (HAS_RE)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_en      (rd_en),
    .tap_word   (tap_word),
    .tap_addr   (tap_addr),
    .rd_data    (rd_data),
    .rd_capture (rd_capture)
  );

endmodule

// File: rtl/spram_rdw_chk.sv
module spram_rdw_chk #(
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int RDW     = 0,
  parameter int SYNC_RD = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_capture,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] tap_word,
  input logic              wr_fire,
  input logic [DATA_W-1:0] wr_bits,
  input logic [DATA_W-1:0] wr_data,
  input logic [LANES-1:0]  wr_en
);

  localparam int LW = DATA_W / LANES;

  logic unused_chk_bits;
  assign unused_chk_bits = ^{wr_data, tap_word};

  // R3
  lane_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> ($countones(wr_bits) == LW * $countones(wr_en)));

  if (SYNC_RD != 0 && RDW == 0) begin : g_old
    // R1
    old_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_capture |=> (rd_data == $past(tap_word)));
    // R6
    old_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_capture |=> $stable(rd_data));
  end

  if (SYNC_RD != 0 && RDW == 1) begin : g_new
    // R2
    new_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_capture && wr_fire && (&wr_bits)) |=> (rd_data == $past(wr_data)));
    // R7
    new_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_capture && !wr_fire) |=> $stable(rd_data));
  end

endmodule

bind spram_rdw spram_rdw_chk #(
  .DATA_W  (DATA_W),
  .LANES   (LANES),
  .RDW     (RDW),
  .SYNC_RD (SYNC_RD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_capture (rd_capture),
  .rd_data    (rd_data),
  .tap_word   (tap_word),
  .wr_fire    (wr_fire),
  .wr_bits    (wr_bits),
  .wr_data    (wr_data),
  .wr_en      (wr_en)
);

// File: tb/sim_spram_rdw.sv
`timescale 1ns/1ps
module sim_spram_rdw;

  localparam int W  = 16;
  localparam int D  = 24;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [1:0]    wr_en = '0;
  logic          we1;
  logic [W-1:0]  rd0, rd1, rd2, rd3, rd4;

  assign we1 = |wr_en;

  always #10 clk = ~clk;

  // Old-data, registered, with read enable
  spram_rdw #(.DATA_W(W), .DEPTH(D), .LANE_W(8), .RDW(0), .SYNC_RD(1), .HAS_WR(1), .HAS_RE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd0), .wr_data(wr_data), .wr_en(wr_en));
  // New-data, registered, with read enable
  spram_rdw #(.DATA_W(W), .DEPTH(D), .LANE_W(8), .RDW(1), .SYNC_RD(1), .HAS_WR(1), .HAS_RE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd1), .wr_data(wr_data), .wr_en(wr_en));
  // Combinational read, new-data selection irrelevant
  spram_rdw #(.DATA_W(W), .DEPTH(D), .LANE_W(8), .RDW(1), .SYNC_RD(0), .HAS_WR(1), .HAS_RE(1)) u2 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd2), .wr_data(wr_data), .wr_en(wr_en));
  // Granularity 0 -> whole word, no read enable, old-data registered
  spram_rdw #(.DATA_W(W), .DEPTH(D), .LANE_W(0), .RDW(0), .SYNC_RD(1), .HAS_WR(1), .HAS_RE(0)) u3 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd3), .wr_data(wr_data), .wr_en(we1));
  // Read-only, granularity >= width, combinational read
  spram_rdw #(.DATA_W(W), .DEPTH(D), .LANE_W(32), .RDW(0), .SYNC_RD(0), .HAS_WR(0), .HAS_RE(1)) u4 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd4), .wr_data(wr_data), .wr_en(we1));

  // Shadow arrays: lane-masked (u0..u2) and whole-word (u3)
  logic [W-1:0] sh  [D];
  logic [W-1:0] sh3 [D];
  logic [W-1:0] e0, e3;
  int           a1;
  int           n_chk = 0;
  int           n_err = 0;

  function automatic logic [W-1:0] peek(input int a);
    return (a < D) ? sh[a] : '0;
  endfunction

  function automatic logic [W-1:0] peek3(input int a);
    return (a < D) ? sh3[a] : '0;
  endfunction

  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                              input logic [1:0] we);
    logic [W-1:0] r;
    r = old;
    if (we[0]) r[7:0]  = nw[7:0];
    if (we[1]) r[15:8] = nw[15:8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock of stimulus; outputs compared at the following falling edge
  task automatic step(input int a, input logic [W-1:0] wd, input logic [1:0] we, input logic re);
    logic [W-1:0] old, old3, pre4;
    addr = a[AW-1:0]; wr_data = wd; wr_en = we; rd_en = re;
    old  = peek(a);
    old3 = peek3(a);
    if (re) begin
      e0 = old;
      a1 = a;
    end
    if (a < D) begin
      sh[a] = lane_merge(sh[a], wd, we);
      if (|we) sh3[a] = wd;
    end
    e3 = old3;
    #1 pre4 = rd4;
    @(posedge clk);
    @(negedge clk);
    chk("R1 R6 u0 old-data", rd0, e0);
    chk("R2 R7 u1 new-data", rd1, peek(a1));
    chk("R5 R10 u2 comb", rd2, peek(a));
    chk("R4 R8 u3 whole-word", rd3, e3);
    chk("R9 u4 read-only", rd4, pre4);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [W-1:0] v0;
    void'($urandom(32'h5EED_0042));
    // Zero-fill under reset (writes are not gated by reset)
    @(negedge clk);
    for (int a = 0; a < D; a++) begin
      addr = a[AW-1:0]; wr_data = '0; wr_en = 2'b11; rd_en = 1'b1;
      sh[a] = '0; sh3[a] = '0;
      @(negedge clk);
    end
    wr_en = '0; rd_en = 1'b0; addr = '0;
    @(negedge clk);
    // R11: reset state of the read-side registers
    chk("R11 u0 reset", rd0, '0);
    chk("R11 u1 reset", rd1, '0);
    chk("R11 u3 reset", rd3, '0);
    rst_n = 1'b1;
    e0 = '0; e3 = '0; a1 = 0;
    @(negedge clk);

    // R1 / R2: same-address read-during-write
    step(5, 16'hA1A1, 2'b11, 1'b1);
    step(5, 16'hB2B2, 2'b11, 1'b1);
    chk("R1 old word on collision", rd0, 16'hA1A1);
    chk("R2 new word on collision", rd1, 16'hB2B2);

    // R3: partial lanes
    step(7, 16'h1234, 2'b11, 1'b1);
    step(7, 16'hFFFF, 2'b01, 1'b1);
    chk("R3 low lane only", rd2, 16'h12FF);
    step(7, 16'hAB00, 2'b10, 1'b1);
    chk("R3 high lane only", rd2, 16'hABFF);

    // R6 / R7: read enable low
    step(9, 16'hC3C3, 2'b11, 1'b1);
    step(9, 16'h0000, 2'b00, 1'b1);
    v0 = rd0;
    step(2, 16'h5A5A, 2'b11, 1'b0);
    step(9, 16'h7777, 2'b11, 1'b0);
    chk("R6 old-data output frozen", rd0, v0);
    chk("R7 held address follows write", rd1, 16'h7777);

    // R4 / R8: whole-word fallback with one enable bit, read every cycle
    step(4, 16'hBEEF, 2'b01, 1'b0);
    step(4, 16'h0000, 2'b00, 1'b0);
    chk("R4 single bit writes whole word", rd3, 16'hBEEF);
    chk("R8 read without enable", rd3, 16'hBEEF);

    // R10: out-of-range address
    step(26, 16'hFFFF, 2'b11, 1'b1);
    chk("R10 out-of-range reads zero", rd2, 16'h0000);
    step(2, 16'h0000, 2'b00, 1'b1);
    step(2, 16'h0000, 2'b00, 1'b1);
    chk("R10 in-range word untouched", rd0, 16'h5A5A);

    // Random mix, small address range to force collisions
    for (int i = 0; i < 600; i++) begin
      int          a;
      logic [W-1:0] d;
      logic [1:0]   we;
      logic         re;
      a  = $urandom_range(0, 27);
      d  = W'($urandom);
      we = 2'($urandom);
      re = ($urandom_range(0, 9) < 7);
      step(a, d, we, re);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule